// File: doc/BRIEF.md
# Configuration Register Write Guard

This block holds a set of configuration registers for a non-volatile memory controller and keeps them behind a protect flag. The flag lives in the control register. While it is raised, bus writes to the guarded registers are dropped and a sticky error bit is raised in the status register. Software clears that bit by writing a one to it.

The protect flag cannot be changed by an ordinary control write. Software must first write three key values in order across two key registers. The next control write after a complete key sequence loads every bit, the protect flag included, and uses up the unlock. This holds even when protection is already off. Writes that arrive out of order restart the key detector. Protection is on out of reset.

Top module: `cfgWriteGuard`

## Requirements
- R1: After reset the control output is 0x00000002 (protect flag at bit 1 set), all other register outputs are zero, and the status output is zero.
- R2: While the protect flag is 1, writes to the guarded registers (offsets 0x04, 0x08, 0x0c, 0x20, 0x24, 0x28) leave them unchanged.
- R3: While the protect flag is 0, a write to a guarded register appears on its output one clock after the write cycle.
- R4: A dropped write, to a guarded register or to control without an unlock, while the flag is 1 sets status bit 1 one clock later.
- R5: A write to status (offset 0x2c) with bit 1 set clears status bit 1. The same write with bit 1 clear has no effect.
- R6: Writing 0x7123 to offset 0x18, then 0x812a to offset 0x1c, then 0xbee1 to offset 0x18 on consecutive writes grants an unlock. The next control write (offset 0x00) then loads all 32 bits, bit 1 included, even while protected.
- R7: A control write without an unlock while the flag is 0 loads every bit except bit 1, which keeps its value.
- R8: A control write without an unlock while the flag is 1 is dropped entirely.
- R9: Any write that breaks the key order restarts detection. A write of 0x7123 to offset 0x18 always restarts at step one, so a repeated first key still leads to an unlock.
- R10: The unlock is consumed by the next control write, even when that write leaves bit 1 unchanged.
- R11: Once granted, the unlock survives writes to registers other than control and the two key registers.
- R12: Writes to unmapped offsets and to the key registers change no register output and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Byte offset of the write |
| wrData | input | DATA_W | Write data |
| ctrlOut | output | DATA_W | Control register, bit 1 is the protect flag |
| timing0Out | output | DATA_W | Timing register at 0x04 |
| timing1Out | output | DATA_W | Timing register at 0x08 |
| timing2Out | output | DATA_W | Timing register at 0x0c |
| addrOut | output | DATA_W | Operation address at 0x20 |
| bufDataOut | output | DATA_W | Buffer data at 0x24 |
| bufIdxOut | output | DATA_W | Buffer index at 0x28 |
| statusOut | output | DATA_W | Status, bit 1 is the sticky protect error |

## Verification
The assertions check several rules on every cycle. A guarded register holds still under a protected write. The error bit rises after a dropped write and falls after a clearing write. The protect flag survives a control write made without an unlock. An unlock appears only from the second key step and is gone after any control write. Other behaviours show only in the bench scenarios: the full key order, the restart behaviour of interrupted or repeated keys, an unlock that persists across unrelated writes, and the values loaded into each register.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int ADDR_W   = 8;
  localparam int WP_BIT   = 1;
  localparam int ERR_BIT  = 1;
  localparam int NUM_PROT = 6;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_KEYA   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_KEYB   = 8'h1c;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h2c;

  // guarded registers, output order: timing0, timing1, timing2, addr, bufData, bufIdx
  localparam logic [ADDR_W-1:0] PROT_OFF [NUM_PROT] = '{8'h04, 8'h08, 8'h0c, 8'h20, 8'h24, 8'h28};

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_TWO, SEQ_OPEN} seqState_t;

  typedef struct packed {
    logic ctrlLoad;  // accept a control write
    logic ctrlFull;  // include the protect flag in that write
    logic dataLoad;  // accept a guarded register write
    logic errSet;    // a write was dropped
    logic errClr;    // software clears the error
  } guardStrobes_t;

  function automatic logic isProtAddr(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_PROT; i++) begin
      if (a == PROT_OFF[i]) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/guardCtrl.sv
module guardCtrl
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h7123,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'h812a,
  parameter logic [DATA_W-1:0] KEY_THIRD  = 32'hbee1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpNow,
  output guardStrobes_t     strobes,
  output logic              unlocked
);
  seqState_t state, stateNext;

  logic isCtrl, isKeyA, isKeyB, isStatus, isProt;
  assign isCtrl   = (wrAddr == OFF_CTRL);
  assign isKeyA   = (wrAddr == OFF_KEYA);
  assign isKeyB   = (wrAddr == OFF_KEYB);
  assign isStatus = (wrAddr == OFF_STATUS);
  assign isProt   = isProtAddr(wrAddr);

  assign unlocked = (state == SEQ_OPEN);

  always_comb begin
    strobes.ctrlLoad = wrEn && isCtrl && (!wpNow || unlocked);
    strobes.ctrlFull = unlocked;
    strobes.dataLoad = wrEn && isProt && !wpNow;
    strobes.errSet   = wrEn && wpNow && (isProt || (isCtrl && !unlocked));
    strobes.errClr   = wrEn && isStatus && wrData[ERR_BIT];
  end

  always_comb begin
    stateNext = state;
    if (wrEn) begin
      if (unlocked && isCtrl)                                stateNext = SEQ_IDLE;
      else if (isKeyA && wrData == KEY_FIRST)                stateNext = SEQ_ONE;
      else if (state == SEQ_ONE && isKeyB && wrData == KEY_SECOND) stateNext = SEQ_TWO;
      else if (state == SEQ_TWO && isKeyA && wrData == KEY_THIRD)  stateNext = SEQ_OPEN;
      else if (unlocked && !isKeyA && !isKeyB)               stateNext = SEQ_OPEN;
      else                                                   stateNext = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  // R6: an unlock only follows the second key step or an existing unlock
  a_r6_open_from_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(state) == SEQ_TWO);

  // R10: any control write ends the unlock
  a_r10_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCtrl) |=> !unlocked);

  // R12: key register writes never flag an error
  a_r12_key_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (isKeyA || isKeyB)) |-> !strobes.errSet);
endmodule

// File: rtl/guardRegs.sv
module guardRegs
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  guardStrobes_t              strobes,
  output logic                       wpNow,
  output logic [DATA_W-1:0]          ctrlReg,
  output logic [NUM_PROT*DATA_W-1:0] protFlat,
  output logic [DATA_W-1:0]          statusReg
);
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << WP_BIT;

  logic errFlag;

  assign wpNow = ctrlReg[WP_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
    end else if (strobes.ctrlLoad) begin
      ctrlReg <= wrData;
      if (!strobes.ctrlFull) ctrlReg[WP_BIT] <= ctrlReg[WP_BIT];
    end
  end

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
    always_ff @(posedge clk) begin
      if (!rstN)
        protFlat[i*DATA_W +: DATA_W] <= '0;
      else if (strobes.dataLoad && wrAddr == PROT_OFF[i])
        protFlat[i*DATA_W +: DATA_W] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               errFlag <= 1'b0;
    else if (strobes.errSet) errFlag <= 1'b1;
    else if (strobes.errClr) errFlag <= 1'b0;
  end

  always_comb begin
    statusReg = '0;
    statusReg[ERR_BIT] = errFlag;
  end

  // R2: guarded registers hold under a protected write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isProtAddr(wrAddr) && ctrlReg[WP_BIT]) |=> $stable(protFlat));

  // R4: a protected guarded write raises the error
  a_r4_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isProtAddr(wrAddr) && ctrlReg[WP_BIT]) |=> errFlag);

  // R5: a clearing status write drops the error
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OFF_STATUS && wrData[ERR_BIT]) |=> !errFlag);

  // R7: the flag survives a control write without an unlock
  a_r7_keep_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctrlLoad && !strobes.ctrlFull) |=> $stable(ctrlReg[WP_BIT]));
endmodule

// File: rtl/cfgWriteGuard.sv
module cfgWriteGuard
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h7123,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'h812a,
  parameter logic [DATA_W-1:0] KEY_THIRD  = 32'hbee1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] timing0Out,
  output logic [DATA_W-1:0] timing1Out,
  output logic [DATA_W-1:0] timing2Out,
  output logic [DATA_W-1:0] addrOut,
  output logic [DATA_W-1:0] bufDataOut,
  output logic [DATA_W-1:0] bufIdxOut,
  output logic [DATA_W-1:0] statusOut
);
  guardStrobes_t strobes;
  logic wpNow, unlocked;
  logic [NUM_PROT*DATA_W-1:0] protFlat;

  guardCtrl #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .KEY_THIRD(KEY_THIRD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wpNow(wpNow), .strobes(strobes), .unlocked(unlocked)
  );

  guardRegs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .wpNow(wpNow), .ctrlReg(ctrlOut), .protFlat(protFlat),
    .statusReg(statusOut)
  );

  assign timing0Out = protFlat[0*DATA_W +: DATA_W];
  assign timing1Out = protFlat[1*DATA_W +: DATA_W];
  assign timing2Out = protFlat[2*DATA_W +: DATA_W];
  assign addrOut    = protFlat[3*DATA_W +: DATA_W];
  assign bufDataOut = protFlat[4*DATA_W +: DATA_W];
  assign bufIdxOut  = protFlat[5*DATA_W +: DATA_W];
endmodule

// File: tb/cfgWriteGuard_test.sv
`timescale 1ns/1ps
module cfgWriteGuard_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] ctrlOut, timing0Out, timing1Out, timing2Out, addrOut, bufDataOut, bufIdxOut, statusOut;

  always #2 clk = ~clk;  // 250 MHz

  cfgWriteGuard uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlOut(ctrlOut), .timing0Out(timing0Out), .timing1Out(timing1Out),
    .timing2Out(timing2Out), .addrOut(addrOut), .bufDataOut(bufDataOut),
    .bufIdxOut(bufIdxOut), .statusOut(statusOut)
  );

  typedef struct {
    string tag;
    logic [31:0] v [8];  // ctrl, t0, t1, t2, addr, bufData, bufIdx, status
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state, built from the requirements
  logic [31:0] mCtrl = 32'h2;
  logic [31:0] mReg [6] = '{default: 32'h0};
  bit mErr = 0;
  int mSeq = 0;  // 0 idle, 1 first key, 2 second key, 3 unlocked
  logic [7:0] offs [6] = '{8'h04, 8'h08, 8'h0c, 8'h20, 8'h24, 8'h28};

  function automatic void modelApply(logic [7:0] a, logic [31:0] d);
    bit open = (mSeq == 3);
    bit wp = mCtrl[1];
    int idx = -1;
    for (int i = 0; i < 6; i++) if (a == offs[i]) idx = i;
    if (a == 8'h00) begin
      if (open) mCtrl = d;
      else if (!wp) mCtrl = {d[31:2], mCtrl[1], d[0]};
      else mErr = 1;
    end else if (idx >= 0) begin
      if (!wp) mReg[idx] = d;
      else mErr = 1;
    end else if (a == 8'h2c && d[1]) begin
      mErr = 0;
    end
    if (open && a == 8'h00) mSeq = 0;
    else if (a == 8'h18 && d == 32'h7123) mSeq = 1;
    else if (mSeq == 1 && a == 8'h1c && d == 32'h812a) mSeq = 2;
    else if (mSeq == 2 && a == 8'h18 && d == 32'hbee1) mSeq = 3;
    else if (open && a != 8'h18 && a != 8'h1c) mSeq = 3;
    else mSeq = 0;
  endfunction

  function automatic void pushExp(string tag);
    expItem_t it;
    it.tag = tag;
    it.v[0] = mCtrl;
    for (int i = 0; i < 6; i++) it.v[i+1] = mReg[i];
    it.v[7] = {30'b0, mErr, 1'b0};
    expQ.push_back(it);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    modelApply(a, d);
    pushExp(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wrEn = 1'b0;
    pushExp(tag);
  endtask

  task automatic unlockSeq(input string tag);
    wr(8'h18, 32'h7123, tag);
    wr(8'h1c, 32'h812a, tag);
    wr(8'h18, 32'hbee1, tag);
  endtask

  // monitor: compare one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act [8];
        it = expQ.pop_front();
        act = '{ctrlOut, timing0Out, timing1Out, timing2Out, addrOut, bufDataOut, bufIdxOut, statusOut};
        checks++;
        for (int i = 0; i < 8; i++) begin
          if (act[i] !== it.v[i]) begin
            fails++;
            $display("FAIL %s reg%0d actual %h expected %h", it.tag, i, act[i], it.v[i]);
            break;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R1 reset values");
    // R2 / R4: guarded writes dropped while protected, error latched
    wr(8'h04, 32'h1111_0004, "R2 R4 timing0 protected");
    wr(8'h28, 32'h0000_0007, "R2 bufIdx protected");
    // R5: bit1 clear has no effect, bit1 set clears
    wr(8'h2c, 32'h0000_0001, "R5 status write without bit1");
    wr(8'h2c, 32'h0000_0002, "R5 status clear");
    // R8: control write without unlock while protected
    wr(8'h00, 32'h0000_0000, "R8 control dropped");
    wr(8'h2c, 32'hffff_ffff, "R5 status clear again");
    // R6 / R10: unlock, then clear the flag
    unlockSeq("R6 key steps");
    wr(8'h00, 32'h0000_0100, "R6 R10 control full load");
    // R3: guarded registers load while unprotected
    wr(8'h04, 32'hA5A5_0001, "R3 timing0");
    wr(8'h08, 32'hA5A5_0002, "R3 timing1");
    wr(8'h0c, 32'hA5A5_0003, "R3 timing2");
    wr(8'h20, 32'h0000_3000, "R3 addr");
    wr(8'h24, 32'hDEAD_BEEF, "R3 bufData");
    wr(8'h28, 32'h0000_0005, "R3 bufIdx");
    // R7: flag kept when no unlock
    wr(8'h00, 32'h0000_01f2, "R7 control keeps flag");
    // R9: interrupted sequence does not unlock
    wr(8'h18, 32'h7123, "R9 key1");
    wr(8'h20, 32'h0000_4000, "R9 interrupting write");
    wr(8'h1c, 32'h812a, "R9 key2 out of order");
    wr(8'h18, 32'hbee1, "R9 key3 out of order");
    wr(8'h00, 32'h0000_0002, "R9 flag stays clear");
    // R9: wrong value at second key
    wr(8'h18, 32'h7123, "R9 key1 again");
    wr(8'h1c, 32'h1234, "R9 wrong second key");
    wr(8'h18, 32'hbee1, "R9 third without second");
    wr(8'h00, 32'h0000_0003, "R9 flag still clear");
    // R9: repeated first key restarts at step one
    wr(8'h18, 32'h7123, "R9 key1 first");
    unlockSeq("R9 repeated key1");
    wr(8'h00, 32'h0000_0003, "R9 unlock sets flag");
    // R10: unlock consumed by a write that keeps the flag
    unlockSeq("R10 keys");
    wr(8'h00, 32'h0000_0006, "R10 same flag write");
    wr(8'h00, 32'h0000_0000, "R10 no unlock left");
    wr(8'h2c, 32'h0000_0002, "R5 clear");
    // R11: unlock survives other register writes
    unlockSeq("R11 keys");
    wr(8'h0c, 32'h0000_00ff, "R11 R2 protected write while unlocked");
    wr(8'h2c, 32'h0000_0002, "R11 status write while unlocked");
    wr(8'h44, 32'h0000_0001, "R11 unmapped write while unlocked");
    wr(8'h00, 32'h0000_0010, "R11 control full load");
    // R12: unmapped and key writes leave everything alone
    wr(8'h40, 32'hffff_ffff, "R12 unmapped");
    wr(8'h1c, 32'h0000_9999, "R12 key register");
    wr(8'h00, 32'h0000_0002, "R12 R7 after noise");
    // R2 / R4 again with protection restored via unlock
    unlockSeq("R6 keys relock");
    wr(8'h00, 32'h0000_0002, "R6 relock");
    wr(8'h24, 32'h0000_0001, "R2 R4 bufData protected");
    idle("R4 error held");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule